// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This unit sits beside the protocol engine of a two-wire serial bus master. It collects the engine's one-cycle event pulses into sticky status flags. It drives a single interrupt line from the flags that software has enabled. It also offers a small numeric vector that names the most urgent pending source, so a handler can dispatch without scanning the status word.

Software reaches three registers through a simple read/write port. The address decoding is as follows:

- Address 0 holds the enable word.
- Address 1 holds the status word, which is cleared by writing ones.
- Address 2 holds the vector, which is read-only.

Read data is combinational. It appears in the same cycle as the read strobe. A vector read removes the flag that it names, so a handler can loop on the vector until it reads zero.

Top module: `evt_irq_unit`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) clears the enable word and every sticky flag. After reset, irq is 0, the status reads as only the live busy bit, and the vector reads 0.
- R2: A one-cycle event pulse sets its status flag on the next rising edge, and the flag stays set until it is cleared. The flag positions are: arbitration lost at bit 0, no-acknowledge at bit 1, access ready at bit 2, receive ready at bit 3, transmit ready at bit 4, transmit underflow at bit 10 and receive overrun at bit 11.
- R3: A write to address 1 clears every sticky flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R4: Status bit 12 always equals the bus_busy input in the same cycle. A write to that bit has no effect.
- R5: A write to address 0 loads data bits 4:0 into the enable word. A read of address 0 returns the enable word in bits 4:0 and zero in all other bits.
- R6: irq is 1 exactly when some status bit in 4:0 is set together with the matching enable bit. The underflow and overrun flags never raise irq.
- R7: A read of address 2 returns the vector code. The code is 0 when no enabled flag in bits 4:0 is pending. Otherwise it is the flag's bit index plus 1 (1 = arbitration lost, 2 = no-acknowledge, 3 = access ready, 4 = receive ready, 5 = transmit ready). When several enabled flags are pending, the smallest code is reported.
- R8: A vector read that returns a nonzero code clears the flag it reported at the next rising edge. All other flags are left unchanged.
- R9: When an event pulse and a clear (by a status write or by a vector read) hit the same flag in the same cycle, the flag ends up set.
- R10: When reg_rd is low, reg_rdata is 0. A read of address 3 returns 0. Writes to addresses 2 and 3 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ev_arb_lost | input | 1 | Arbitration-lost event pulse |
| ev_nack | input | 1 | No-acknowledge event pulse |
| ev_acc_rdy | input | 1 | Access-ready event pulse |
| ev_rx_rdy | input | 1 | Receive-ready event pulse |
| ev_tx_rdy | input | 1 | Transmit-ready event pulse |
| ev_rx_ovr | input | 1 | Receive-overrun event pulse |
| ev_tx_udf | input | 1 | Transmit-underflow event pulse |
| bus_busy | input | 1 | Live bus-busy level |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid in the cycle of reg_rd |
| irq | output | 1 | Interrupt request level |

## Verification
The assertions assume the following about the inputs:

- Event pulses, strobes and addresses are stable around each rising edge.
- A vector read and a status write may coincide without upsetting the set-over-clear rule.

The stimulus changes every input only on the falling edge. It mixes directed sequences, such as coincident set and clear, and several flags pending at once, with a long random section. In that section pulses, both strobes, all four addresses and busy toggles occur in any combination, so only that input timing is relied upon.

// File: rtl/evt_irq_pkg.sv
// Package: shared register addresses and status bit positions for the
// interrupt status and vector unit.
package evt_irq_pkg;
    localparam int REG_DW  = 16;  // register data width
    localparam int NUM_VEC = 5;   // vectored, maskable event sources
    localparam int POS_UDF = 10;  // transmit underflow flag position
    localparam int POS_OVR = 11;  // receive overrun flag position
    localparam int POS_BB  = 12;  // live bus-busy position

    typedef enum logic [1:0] {
        ADDR_EN   = 2'd0,
        ADDR_STAT = 2'd1,
        ADDR_VEC  = 2'd2,
        ADDR_NONE = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/evt_prio_enc.sv
// Module: fixed-priority encoder. Bit 0 has the highest priority.
// Outputs the winning index plus one (0 when idle) and a one-hot grant.
// Assumes: purely combinational, N >= 1.
module evt_prio_enc #(
    parameter int N  = 5,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  req,
    output logic [CW-1:0] code,
    output logic [N-1:0]  grant
);
    // Scan from the top down so the lowest set index is assigned last.
    always_comb begin
        code  = '0;
        grant = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                code     = CW'(i + 1);
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/evt_sticky_bank.sv
// Module: bank of independent sticky flags.
// A set pulse has priority over a clear in the same cycle.
// Assumes: synchronous active-low reset.
module evt_sticky_bank #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flag_o
);
    for (genvar g = 0; g < W; g++) begin : g_flag
        logic q;
        // Hold one flag: reset clears it, set wins over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= 1'b0;
            else if (set_i[g])
                q <= 1'b1;
            else if (clr_i[g])
                q <= 1'b0;
        end
        assign flag_o[g] = q;
    end
endmodule

// File: rtl/evt_read_mux.sv
// Module: register read multiplexer. Returns zero when no read is
// strobed or when the address is unmapped.
// Assumes: the status word arrives fully assembled.
module evt_read_mux
    import evt_irq_pkg::*;
#(
    parameter int DW = REG_DW,
    parameter int NV = NUM_VEC,
    parameter int CW = $clog2(NV + 1)
) (
    input  logic          rd_en,
    input  logic [1:0]    addr,
    input  logic [NV-1:0] en_word,
    input  logic [DW-1:0] stat_word,
    input  logic [CW-1:0] vec_code,
    output logic [DW-1:0] rdata
);
    // Select the addressed register onto the read bus.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                ADDR_EN:   rdata[NV-1:0] = en_word;
                ADDR_STAT: rdata = stat_word;
                ADDR_VEC:  rdata[CW-1:0] = vec_code;
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/evt_irq_unit.sv
// Module: top of the interrupt status and vector unit.
// Event pulses set sticky flags. Enabled flags in the low field drive irq.
// The vector names the lowest-index enabled pending flag and clears it
// when read.
// Assumes: event pulses last one cycle; bus_busy is synchronous to clk.
module evt_irq_unit
    import evt_irq_pkg::*;
#(
    parameter int DW = REG_DW,
    parameter int NV = NUM_VEC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_arb_lost,
    input  logic          ev_nack,
    input  logic          ev_acc_rdy,
    input  logic          ev_rx_rdy,
    input  logic          ev_tx_rdy,
    input  logic          ev_rx_ovr,
    input  logic          ev_tx_udf,
    input  logic          bus_busy,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq
);
    localparam int NF    = NV + 2;          // vectored flags + underflow + overrun
    localparam int CW    = $clog2(NV + 1);
    localparam int I_UDF = NV;
    localparam int I_OVR = NV + 1;

    logic [NV-1:0] en_q;
    logic [NF-1:0] ev_set, ev_clr, flags;
    logic [NV-1:0] pend, grant;
    logic [CW-1:0] vec_code;
    logic [DW-1:0] stat_word;
    logic          wr_stat, wr_en, vec_rd;
    logic          unused_wdata;

    assign wr_stat      = reg_wr && (reg_addr == ADDR_STAT);
    assign wr_en        = reg_wr && (reg_addr == ADDR_EN);
    assign vec_rd       = reg_rd && (reg_addr == ADDR_VEC);
    assign unused_wdata = ^reg_wdata;

    // Gather the event pulses in flag order.
    always_comb begin
        ev_set        = '0;
        ev_set[0]     = ev_arb_lost;
        ev_set[1]     = ev_nack;
        ev_set[2]     = ev_acc_rdy;
        ev_set[3]     = ev_rx_rdy;
        ev_set[4]     = ev_tx_rdy;
        ev_set[I_UDF] = ev_tx_udf;
        ev_set[I_OVR] = ev_rx_ovr;
    end

    // Form the clear requests from status writes and vector reads.
    always_comb begin
        ev_clr = '0;
        for (int i = 0; i < NV; i++)
            ev_clr[i] = (wr_stat && reg_wdata[i]) || (vec_rd && grant[i]);
        ev_clr[I_UDF] = wr_stat && reg_wdata[POS_UDF];
        ev_clr[I_OVR] = wr_stat && reg_wdata[POS_OVR];
    end

    // Hold the enable word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (wr_en)
            en_q <= reg_wdata[NV-1:0];
    end

    evt_sticky_bank #(.W(NF)) i_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ev_set),
        .clr_i  (ev_clr),
        .flag_o (flags)
    );

    assign pend = flags[NV-1:0] & en_q;

    evt_prio_enc #(.N(NV), .CW(CW)) i_prio (
        .req   (pend),
        .code  (vec_code),
        .grant (grant)
    );

    // Lay the flags and the live busy level out at their status positions.
    always_comb begin
        stat_word           = '0;
        stat_word[NV-1:0]   = flags[NV-1:0];
        stat_word[POS_UDF]  = flags[I_UDF];
        stat_word[POS_OVR]  = flags[I_OVR];
        stat_word[POS_BB]   = bus_busy;
    end

    assign irq = |pend;

    evt_read_mux #(.DW(DW), .NV(NV), .CW(CW)) i_rmux (
        .rd_en     (reg_rd),
        .addr      (reg_addr),
        .en_word   (en_q),
        .stat_word (stat_word),
        .vec_code  (vec_code),
        .rdata     (reg_rdata)
    );
endmodule

// File: rtl/evt_irq_chk.sv
// Module: assertion checker for evt_irq_unit, bound to the top.
// Assumes: inputs change away from the rising edge.
module evt_irq_chk
    import evt_irq_pkg::*;
#(
    parameter int DW = REG_DW,
    parameter int NV = NUM_VEC
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ev_arb_lost,
    input logic          ev_nack,
    input logic          ev_tx_udf,
    input logic          bus_busy,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic [1:0]    reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic [DW-1:0] reg_rdata,
    input logic          irq,
    input logic [NV-1:0] en_q,
    input logic [DW-1:0] stat_word
);
    // R2
    arb_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_arb_lost |=> stat_word[0]);

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_nack && reg_wr && reg_addr == ADDR_STAT && reg_wdata[1]) |=> stat_word[1]);

    // R3
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_STAT && reg_wdata[POS_UDF] && !ev_tx_udf)
        |=> !stat_word[POS_UDF]);

    // R4
    busy_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_STAT) |-> (reg_rdata[POS_BB] == bus_busy));

    // R6
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq);

    // R7
    vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_VEC && !irq) |-> (reg_rdata == '0));

    // R8
    vec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_VEC && reg_rdata == DW'(1) && !ev_arb_lost)
        |=> !stat_word[0]);

    // R10
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |-> (reg_rdata == '0));
endmodule

bind evt_irq_unit evt_irq_chk #(.DW(DW), .NV(NV)) i_evt_irq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_arb_lost (ev_arb_lost),
    .ev_nack     (ev_nack),
    .ev_tx_udf   (ev_tx_udf),
    .bus_busy    (bus_busy),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .irq         (irq),
    .en_q        (en_q),
    .stat_word   (stat_word)
);

// File: tb/test_evt_irq_unit.sv
// Bench: behavioural reference model compared with the outputs every cycle.
module test_evt_irq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  ev = '0;        // 0 arb,1 nack,2 acc,3 rx,4 tx,5 udf,6 ovr
    logic        bb = 1'b0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int    n_chk = 0, n_fail = 0;
    string cur_req = "R1";
    logic [15:0] m_stat = '0;
    logic [4:0]  m_en = '0;

    always #4 clk = ~clk;

    evt_irq_unit i_evt_irq_unit (
        .clk(clk), .rst_n(rst_n),
        .ev_arb_lost(ev[0]), .ev_nack(ev[1]), .ev_acc_rdy(ev[2]),
        .ev_rx_rdy(ev[3]), .ev_tx_rdy(ev[4]), .ev_rx_ovr(ev[6]),
        .ev_tx_udf(ev[5]), .bus_busy(bb),
        .reg_wr(wr), .reg_rd(rd), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata), .irq(irq)
    );

    function automatic int m_vec();
        for (int i = 0; i < 5; i++)
            if (m_stat[i] && m_en[i]) return i + 1;
        return 0;
    endfunction

    function automatic logic [15:0] m_rdata();
        if (!rd) return 16'h0;
        case (addr)
            2'd0:    return {11'b0, m_en};
            2'd1:    return m_stat | (bb ? 16'h1000 : 16'h0);
            2'd2:    return 16'(m_vec());
            default: return 16'h0;
        endcase
    endfunction

    task automatic check(string what, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    // Compare before the edge, advance the model, then return inputs to idle.
    task automatic tick();
        logic [15:0] clr, setm;
        int v;
        #1;
        check("irq", {15'b0, irq}, {15'b0, |(m_stat[4:0] & m_en)});
        check("rdata", rdata, m_rdata());
        if (!rst_n) begin
            m_stat = '0;
            m_en   = '0;
        end else begin
            v    = m_vec();
            clr  = (wr && addr == 2'd1) ? (wdata & 16'h0C1F) : 16'h0;
            if (rd && addr == 2'd2 && v != 0) clr[v-1] = 1'b1;
            setm = {4'b0, ev[6], ev[5], 5'b0, ev[4:0]};
            m_stat = (m_stat & ~clr) | setm;
            if (wr && addr == 2'd0) m_en = wdata[4:0];
        end
        @(negedge clk);
        ev = '0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic do_wr(logic [1:0] a, logic [15:0] d);
        addr = a; wdata = d; wr = 1'b1; tick();
    endtask

    task automatic do_rd(logic [1:0] a);
        addr = a; rd = 1'b1; tick();
    endtask

    task automatic do_ev(logic [6:0] e);
        ev = e; tick();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        tick(); tick();
        rst_n = 1'b1;
        do_rd(2'd0); do_rd(2'd1); do_rd(2'd2);
        // R2: each event alone sets its flag
        cur_req = "R2";
        for (int i = 0; i < 7; i++) begin
            do_ev(7'(1 << i)); do_rd(2'd1);
        end
        // R3: write-one-to-clear, zeros leave flags
        cur_req = "R3";
        do_wr(2'd1, 16'h0405); do_rd(2'd1);
        do_wr(2'd1, 16'h0000); do_rd(2'd1);
        do_wr(2'd1, 16'hFFFF); do_rd(2'd1);
        // R4: live busy, writes ignored
        cur_req = "R4";
        bb = 1'b1; do_rd(2'd1);
        do_wr(2'd1, 16'h1000); do_rd(2'd1);
        bb = 1'b0; do_rd(2'd1);
        // R5: enable register
        cur_req = "R5";
        do_wr(2'd0, 16'hFFFF); do_rd(2'd0);
        do_wr(2'd0, 16'h0000); do_rd(2'd0);
        // R6: interrupt masking
        cur_req = "R6";
        do_ev(7'h7F); tick();
        do_wr(2'd0, 16'h0010); tick();
        do_wr(2'd1, 16'h0010); tick();
        do_wr(2'd0, 16'h0000);
        do_wr(2'd1, 16'h0C1F);
        do_ev(7'h60); do_wr(2'd0, 16'h001F); tick();
        // R7 and R8: multiple pending, drained through the vector
        cur_req = "R7";
        do_wr(2'd1, 16'h0C1F);
        do_ev(7'h1A);
        cur_req = "R8";
        for (int i = 0; i < 4; i++) do_rd(2'd2);
        cur_req = "R7";
        do_ev(7'h1F); do_wr(2'd0, 16'h0006);
        do_rd(2'd2); do_rd(2'd2); do_rd(2'd2); do_rd(2'd1);
        do_wr(2'd0, 16'h001F); do_wr(2'd1, 16'h0C1F);
        // R9: set wins over a write clear and over a vector read
        cur_req = "R9";
        do_ev(7'h02);
        ev = 7'h02; do_wr(2'd1, 16'h0002); do_rd(2'd1);
        ev = 7'h02; do_rd(2'd2); do_rd(2'd1);
        // R10: idle bus, unmapped address, ignored writes
        cur_req = "R10";
        do_rd(2'd3);
        do_wr(2'd2, 16'hFFFF); do_wr(2'd3, 16'hFFFF);
        do_rd(2'd0); do_rd(2'd1); tick();
        // R1: reset in mid-run
        cur_req = "R1";
        do_ev(7'h7F); rst_n = 1'b0; tick(); rst_n = 1'b1;
        do_rd(2'd1); do_rd(2'd0);
        // R6: mixed random traffic
        cur_req = "R6";
        for (int i = 0; i < 3000; i++) begin
            ev    = 7'($urandom) & 7'($urandom);
            bb    = 1'($urandom);
            addr  = 2'($urandom);
            wdata = 16'($urandom);
            wr    = ($urandom % 4) == 0;
            rd    = ($urandom % 2) == 0;
            tick();
        end
        finish_run();
    end
endmodule